// File: doc/BRIEF.md
# Asymmetric Triangle-Carrier Three-Leg PWM

This block drives the three upper and three lower switches of a three-phase bridge. A single up-down counter forms a triangular carrier that all three legs share. Each leg compares its own duty word against the carrier. A new word is taken at every carrier turning point, both at the peak and at the valley. The rising half and the falling half of one carrier period can therefore carry different duties. This lets an upstream duty calculator correct its voltage error twice per carrier period, and the pulses it produces become asymmetric.

The block requests the next set of words with a one-cycle strobe. The strobe comes one clock before the edge that captures the words, so the duty source has a full cycle to present them. Each leg drives a complementary pair of gates. The rising edge of every gate is held back by a programmable count of clocks, and its falling edge is not delayed. A synchronous enable turns all gates off and holds the carrier at its start.

Top module: `asym_tri_pwm`

## Requirements
- R1: After a clock edge with `rst` high, all six gates are low, `duty_req` is low, and the carrier restarts at 0 counting up.
- R2: While enabled, the carrier counts up by one per clock from 0 to 2^(DUTY_W-1)-1. It keeps that top value for one more cycle, which is the first falling cycle, then counts down to 0 and starts rising again. Each half lasts 2^(DUTY_W-1) clocks, so consecutive `duty_req` pulses are exactly 2^(DUTY_W-1) cycles apart.
- R3: Within a half period, the drive request of a leg is high in exactly those cycles where twice the carrier value is below that leg's active duty word. That gives ceil(d/2) cycles, placed at the start of a rising half and at the end of a falling half.
- R4: The duty inputs are captured only at the clock edge that ends a half period, or at any edge while disabled. Changes to them at any other time have no effect on the gates.
- R5: A duty word of 0 keeps the leg's request low for its whole half period. A word of 2^DUTY_W-1 keeps it high for the whole half.
- R6: The upper gate is the leg's request and the lower gate is its inverse. A gate is high in a cycle only when its level has been high for the `dead_cycles`+1 cycles just before. It drops in the cycle after its level drops.
- R7: The upper and lower gates of a leg are never high in the same cycle.
- R8: An edge with `en` low makes all gates low in the next cycle and returns the carrier to 0 counting up. After re-enable, the first rising half uses the words present at the last disabled edge.
- R9: `duty_req` is high only while enabled, and only in the second-to-last cycle of each half: carrier at top-1 while rising, carrier at 1 while falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous run enable |
| duty_a | input | DUTY_W | Duty word for leg A |
| duty_b | input | DUTY_W | Duty word for leg B |
| duty_c | input | DUTY_W | Duty word for leg C |
| dead_cycles | input | DT_W | Rising-edge delay in clocks |
| duty_req | output | 1 | Strobe one clock before duty capture |
| gate_hi | output | 3 | Upper switch gates, bit 0 is leg A |
| gate_lo | output | 3 | Lower switch gates, bit 0 is leg A |

## Verification
`duty_req` is decoded from the carrier state, so it is valid in the same cycle as the count that causes it. A duty word captured at a turning edge affects the leg request from the very next cycle. The gate register adds one more cycle, plus `dead_cycles` on a rising edge. The bench runs its own carrier, duty-capture and hold-count model. It advances that model once per cycle with exactly the inputs it drove, and compares all outputs half a period after each edge. In this way every output is checked in the cycle in which it is due, with every register on the path counted.

// File: rtl/asym_pwm_pkg.sv
package asym_pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } carrier_dir_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_level_t;

    function automatic carrier_dir_e flip_dir(input carrier_dir_e d);
        return (d == DIR_UP) ? DIR_DOWN : DIR_UP;
    endfunction

endpackage

// File: rtl/tri_carrier.sv
module tri_carrier
    import asym_pwm_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output carrier_dir_e     dir,
    output logic             turn,
    output logic             req
);
    localparam logic [CNT_W-1:0] TOP_V    = '1;
    localparam logic [CNT_W-1:0] TOP_M1   = TOP_V - 1'b1;
    localparam logic [CNT_W-1:0] BOTTOM_1 = {{(CNT_W-1){1'b0}}, 1'b1};

    // last cycle of a half: top while rising, zero while falling
    assign turn = (dir == DIR_UP) ? (cnt == TOP_V) : (cnt == '0);
    // one cycle ahead of the capture edge
    assign req  = en && ((dir == DIR_UP) ? (cnt == TOP_M1) : (cnt == BOTTOM_1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (turn) begin
            dir <= flip_dir(dir);
        end else if (dir == DIR_UP) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/half_duty_bank.sv
module half_duty_bank #(
    parameter int DUTY_W = 8,
    parameter int NLEG   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [NLEG-1:0][DUTY_W-1:0]  duty_in,
    input  logic [DUTY_W-2:0]            cnt,
    output logic [NLEG-1:0][DUTY_W-1:0]  duty_act,
    output logic [NLEG-1:0]              above
);
    for (genvar p = 0; p < NLEG; p++) begin : g_leg
        always_ff @(posedge clk) begin
            if (rst) begin
                duty_act[p] <= '0;
            end else if (load) begin
                duty_act[p] <= duty_in[p];
            end
        end
        // doubled count against the full-width word: 0 never, all-ones always
        assign above[p] = ({cnt, 1'b0} < duty_act[p]);
    end
endmodule

// File: rtl/rise_delay.sv
module rise_delay #(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            level,
    input  logic [DT_W-1:0] dly,
    output logic            gate
);
    logic [DT_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            gate <= 1'b0;
        end else begin
            if (!level) begin
                held <= '0;
            end else if (held != '1) begin
                held <= held + 1'b1;
            end
            gate <= level && (held >= dly);
        end
    end
endmodule

// File: rtl/asym_tri_pwm.sv
module asym_tri_pwm
    import asym_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int DT_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [DUTY_W-1:0] duty_c,
    input  logic [DT_W-1:0]   dead_cycles,
    output logic              duty_req,
    output logic [2:0]        gate_hi,
    output logic [2:0]        gate_lo
);
    localparam int NLEG  = 3;
    localparam int CNT_W = DUTY_W - 1;

    logic [CNT_W-1:0]             cnt_w;
    carrier_dir_e                 dir_w;
    logic                         turn_w;
    logic [NLEG-1:0][DUTY_W-1:0]  duty_in_w;
    logic [NLEG-1:0][DUTY_W-1:0]  duty_act;
    logic [NLEG-1:0]              above_w;
    leg_level_t [NLEG-1:0]        want;

    assign duty_in_w = {duty_c, duty_b, duty_a};

    tri_carrier #(.CNT_W(CNT_W)) carrier_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cnt  (cnt_w),
        .dir  (dir_w),
        .turn (turn_w),
        .req  (duty_req)
    );

    half_duty_bank #(.DUTY_W(DUTY_W), .NLEG(NLEG)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .load     (!en || turn_w),
        .duty_in  (duty_in_w),
        .cnt      (cnt_w),
        .duty_act (duty_act),
        .above    (above_w)
    );

    for (genvar p = 0; p < NLEG; p++) begin : g_leg
        assign want[p].hi = en &&  above_w[p];
        assign want[p].lo = en && !above_w[p];

        rise_delay #(.DT_W(DT_W)) hi_i (
            .clk   (clk),
            .rst   (rst),
            .level (want[p].hi),
            .dly   (dead_cycles),
            .gate  (gate_hi[p])
        );

        rise_delay #(.DT_W(DT_W)) lo_i (
            .clk   (clk),
            .rst   (rst),
            .level (want[p].lo),
            .dly   (dead_cycles),
            .gate  (gate_lo[p])
        );
    end
endmodule

// File: rtl/asym_tri_pwm_chk.sv
module asym_tri_pwm_chk
    import asym_pwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  en,
    input logic                  duty_req,
    input logic [2:0]            gate_hi,
    input logic [2:0]            gate_lo,
    input logic [DUTY_W-2:0]     cnt,
    input carrier_dir_e          dir,
    input logic                  turn,
    input logic [3*DUTY_W-1:0]   duty_act
);
    // R7: complementary pair never overlaps
    assert_leg_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b000);

    // R8: a disabled edge clears every gate
    assert_gates_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

    // R9: the request is a single-cycle strobe
    assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
        duty_req |=> !duty_req);

    // R4: active words move only at a turning edge or while disabled
    assert_duty_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !turn) |=> $stable(duty_act));

    // R2: rising carrier steps by exactly one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && dir == DIR_UP && !turn) |=> (cnt == $past(cnt) + 1'b1));
endmodule

bind asym_tri_pwm asym_tri_pwm_chk #(.DUTY_W(DUTY_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .duty_req (duty_req),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .cnt      (cnt_w),
    .dir      (dir_w),
    .turn     (turn_w),
    .duty_act (duty_act)
);

// File: tb/asym_tri_pwm_tb_top.sv
`timescale 1ns/1ps
module asym_tri_pwm_tb_top;
    localparam int DW   = 8;
    localparam int TW   = 10;
    localparam int HALF = 1 << (DW - 1);
    localparam int TOPV = HALF - 1;
    localparam int FULL = (1 << DW) - 1;
    localparam int SATV = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] da = '0, db = '0, dc = '0;
    logic [TW-1:0] dt = '0;
    logic          req;
    logic [2:0]    ghi, glo;

    always #2 clk = ~clk;

    asym_tri_pwm #(.DUTY_W(DW), .DT_W(TW)) dut_i (
        .clk(clk), .rst(rst), .en(en), .duty_a(da), .duty_b(db), .duty_c(dc),
        .dead_cycles(dt), .duty_req(req), .gate_hi(ghi), .gate_lo(glo)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    int m_cnt = 0;
    bit m_up  = 1;
    int m_duty [3] = '{0, 0, 0};
    int run_h [3] = '{0, 0, 0};
    int run_l [3] = '{0, 0, 0};
    bit eg_h [3] = '{0, 0, 0};
    bit eg_l [3] = '{0, 0, 0};

    // controls set by the sequence, applied inside tick
    bit    nx_rst = 1;
    bit    nx_en  = 0;
    int    nx_dt  = 3;
    int    mode   = 1;
    string tag    = "R1";
    int    gap    = -1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    function automatic bit lvl(input int c, input int d);
        return (2 * c) < d;
    endfunction

    task automatic tick();
        int  eh, el;
        bit  ereq, trn;
        bit  dh, dl;
        int  din [3];
        @(negedge clk);
        eh = 0;
        el = 0;
        for (int p = 0; p < 3; p++) begin
            eh |= int'(eg_h[p]) << p;
            el |= int'(eg_l[p]) << p;
        end
        chk({ghi, glo} == 6'((eh << 3) | el), tag, int'({ghi, glo}), (eh << 3) | el);
        ereq = en && ((m_up && m_cnt == TOPV - 1) || (!m_up && m_cnt == 1));
        chk(req == ereq, "R9", int'(req), int'(ereq));
        chk((ghi & glo) == 3'b000, "R7", int'(ghi & glo), 0);
        if (!en || rst) begin
            gap = -1;
        end else begin
            if (gap >= 0) gap++;
            if (req) begin
                if (gap >= 0) chk(gap == HALF, "R2", gap, HALF);
                gap = 0;
            end
        end

        // drive inputs for the coming edge
        rst = nx_rst;
        en  = nx_en;
        if (mode == 3 && ($urandom % 300) == 0) en = !en;
        nx_en = en;
        dt  = TW'(nx_dt);
        if (mode == 0) begin
            da = DW'($urandom); db = DW'($urandom); dc = DW'($urandom);
        end else if (mode == 2 && req) begin
            da = ($urandom % 2) ? DW'(FULL) : '0;
            db = ($urandom % 2) ? DW'(FULL) : '0;
            dc = ($urandom % 2) ? DW'(FULL) : '0;
        end else if ((mode == 1 || mode == 3) && req) begin
            da = DW'($urandom); db = DW'($urandom); dc = DW'($urandom);
        end
        din[0] = int'(da); din[1] = int'(db); din[2] = int'(dc);

        // advance the model with those inputs
        trn = m_up ? (m_cnt == TOPV) : (m_cnt == 0);
        for (int p = 0; p < 3; p++) begin
            dh = en &&  lvl(m_cnt, m_duty[p]);
            dl = en && !lvl(m_cnt, m_duty[p]);
            if (rst) begin
                eg_h[p] = 0; eg_l[p] = 0; run_h[p] = 0; run_l[p] = 0;
            end else begin
                eg_h[p] = dh && (run_h[p] >= nx_dt);
                eg_l[p] = dl && (run_l[p] >= nx_dt);
                run_h[p] = dh ? ((run_h[p] < SATV) ? run_h[p] + 1 : SATV) : 0;
                run_l[p] = dl ? ((run_l[p] < SATV) ? run_l[p] + 1 : SATV) : 0;
            end
            if (rst) m_duty[p] = 0;
            else if (!en || trn) m_duty[p] = din[p];
        end
        if (rst || !en) begin
            m_cnt = 0; m_up = 1;
        end else if (trn) begin
            m_up = !m_up;
        end else if (m_up) begin
            m_cnt++;
        end else begin
            m_cnt--;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        // R1: reset state
        tag = "R1"; nx_rst = 1; nx_en = 0; nx_dt = 3; mode = 1;
        repeat (4) tick();
        chk(ghi == 3'b000 && glo == 3'b000 && req == 1'b0, "R1", int'({req, ghi, glo}), 0);
        nx_rst = 0;
        repeat (2) tick();
        // R3: proper duty source, new words on each strobe
        tag = "R3"; nx_en = 1; nx_dt = 4; mode = 1;
        repeat (1500) tick();
        // R4: inputs scrambled every cycle; only turning-edge values matter
        tag = "R4"; mode = 0;
        repeat (1500) tick();
        // R5: extremes only
        tag = "R5"; mode = 2; nx_dt = 0;
        repeat (1500) tick();
        // R6: several dead times
        tag = "R6"; mode = 1; nx_dt = 37;
        repeat (1000) tick();
        nx_dt = 0;
        repeat (600) tick();
        nx_dt = 1023;
        repeat (600) tick();
        nx_dt = 2;
        repeat (300) tick();
        // R8: enable toggled at random points
        tag = "R8"; mode = 3; nx_dt = 5;
        repeat (3000) tick();
        mode = 1; nx_en = 0;
        repeat (3) tick();
        chk(ghi == 3'b000 && glo == 3'b000, "R8", int'({ghi, glo}), 0);
        nx_en = 1;
        repeat (700) tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule